// File: doc/BRIEF.md
# Column-Multiplexed Self-Correcting Configuration Chain

This block stores the configuration of a 32-row by 16-column pixel matrix, with 8 bits per pixel and 4096 bits in all. Every stored bit is kept in three copies. A bitwise two-out-of-three vote drives the configuration outputs. On every clock edge the voted value is written back into all three copies, so a single flipped copy is repaired before a second upset can meet it.

Data arrives over a narrow serial path. Each column has its own 256-stage shift chain, and only the column picked by the select input takes part in serial traffic. The serial input reaches that chain alone, and the serial output is taken from that chain's last stage. A load pulse copies the chain into the column's redundant store. A readback pulse does the reverse: the voted store goes into the chain, which is then clocked out for comparison.

A strike input flips one copy of one bit for one cycle. It stands in for a particle hit, so that the repair path can be exercised from the ports.

Top module: `pixcfg_chain`

## Requirements
- R1: After reset, every configuration output bit and the serial output are 0.
- R2: In any cycle where load and readback are both low, the selected column's chain shifts by one place. The serial input enters stage 0 and every stage k moves to stage k+1. The chains of all other columns keep their contents.
- R3: A clock edge with load high and readback low copies the selected column's 256-bit chain into that column's configuration bits. Chain stage k drives output bit `c*256 + k` for column c, where k = row*8 + bit. Configuration bits of other columns do not change.
- R4: A clock edge with readback high copies the selected column's configuration bits into its chain. The following shifts then present stage 255 first on the serial output, then stage 254, and so on.
- R5: When load and readback are high on the same edge, readback wins. The chain is captured and no configuration bit changes.
- R6: A strike (strike enable high; copy index 0, 1 or 2; column index; bit index k) flips one copy of one bit. It never changes any configuration output bit. A copy index of 3 flips nothing.
- R7: The copy flipped by a strike is restored from the vote on the next edge. Strikes on two different copies of the same bit, at least two cycles apart, leave the output unchanged.
- R8: The serial output always equals stage 255 of the chain of the column named by the select input.
- R9: Without a load, configuration bits hold their value, whatever the serial input, the select input or the shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Active-low reset, clears chains and stores |
| col_sel | input | 4 | Column that takes part in serial traffic |
| sdi | input | 1 | Serial data into the selected chain's stage 0 |
| load | input | 1 | Copy selected chain into its redundant store |
| readback | input | 1 | Copy selected store into its chain (has priority over load) |
| sdo | output | 1 | Last stage of the selected chain |
| strike_en | input | 1 | Flip one stored copy this cycle |
| strike_col | input | 4 | Column of the flipped copy |
| strike_copy | input | 2 | Which of the three copies (3 = none) |
| strike_idx | input | 8 | Bit position k within the column |
| cfg_bits | output | 4096 | Voted configuration, column c at `[c*256 +: 256]` |

## Verification
The assertions check the cycle-level rules on every edge. The cases they cover are the shift, hold and capture moves of each chain, the value the store takes on a load, and voted outputs that stay still without a load, including across strike and load-plus-readback cycles. They also check that all three copies agree again one edge after any cycle without a strike. The bench scenarios show what only whole traffic can show. Full 256-bit columns are written with all-ones, all-zeros and random patterns and come back in the right serial order. A chain left half-written while another column is driven is not disturbed. Only the repair makes a strike on a second copy of the same bit harmless; without it, that strike would corrupt the output.

// File: rtl/pixcfg_pkg.sv
package pixcfg_pkg;

   // Per-column chain operation, resolved once per cycle
   typedef enum logic [1:0] {
      OP_HOLD    = 2'd0,
      OP_SHIFT   = 2'd1,
      OP_LOAD    = 2'd2,
      OP_CAPTURE = 2'd3
   } chain_op_t;

   // Readback outranks load; an unselected column only holds
   function automatic chain_op_t pick_op(input logic en, input logic ld, input logic rb);
      if (!en)     return OP_HOLD;
      else if (rb) return OP_CAPTURE;
      else if (ld) return OP_LOAD;
      else         return OP_SHIFT;
   endfunction

endpackage

// File: rtl/pixcfg_shreg.sv
module pixcfg_shreg
   import pixcfg_pkg::*;
#(
   parameter int W = 256
) (
   input  logic          clk,
   input  logic          rst_n,
   input  chain_op_t     op_i,
   input  logic          sdi_i,
   input  logic [W-1:0]  par_i,
   output logic [W-1:0]  q_o
);

   generate
      if (W < 2) begin : g_bad_width
         $error("pixcfg_shreg: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= '0;
      end else begin
         unique case (op_i)
            OP_SHIFT:   q_o <= {q_o[W-2:0], sdi_i};
            OP_CAPTURE: q_o <= par_i;
            default:    q_o <= q_o;
         endcase
      end
   end

   p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_SHIFT) |=> (q_o == {$past(q_o[W-2:0]), $past(sdi_i)}))
      else $error("chain did not shift by one place");

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_HOLD || op_i == OP_LOAD) |=> $stable(q_o))
      else $error("chain moved without shift or capture");

   p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_CAPTURE) |=> (q_o == $past(par_i)))
      else $error("chain did not capture the store");

endmodule

// File: rtl/pixcfg_tmr_store.sv
module pixcfg_tmr_store #(
   parameter int W = 256
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic [W-1:0]        data_i,
   input  logic [2:0][W-1:0]   flip_i,
   output logic [W-1:0]        vote_o
);

   logic [2:0][W-1:0] copy_q;
   logic [W-1:0]      base;

   // Bitwise two-out-of-three majority
   assign vote_o = (copy_q[0] & copy_q[1]) | (copy_q[0] & copy_q[2]) | (copy_q[1] & copy_q[2]);
   // Every edge rewrites all copies from the vote unless new data is loaded
   assign base   = load_i ? data_i : vote_o;

   generate
      for (genvar k = 0; k < 3; k++) begin : g_copy
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) copy_q[k] <= '0;
            else        copy_q[k] <= base ^ flip_i[k];
         end
      end
   endgenerate

   p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (vote_o == $past(data_i)))
      else $error("store did not take the loaded value");

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(vote_o))
      else $error("voted value moved without a load");

   p_scrub_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flip_i == '0) |=> (copy_q[0] == copy_q[1] && copy_q[1] == copy_q[2]))
      else $error("copies still disagree one edge after a strike");

endmodule

// File: rtl/pixcfg_colmux.sv
module pixcfg_colmux #(
   parameter int COLS  = 16,
   parameter int SEL_W = 4
) (
   input  logic [SEL_W-1:0] sel_i,
   input  logic [COLS-1:0]  tail_i,
   output logic [COLS-1:0]  en_o,
   output logic             sdo_o
);

   generate
      for (genvar c = 0; c < COLS; c++) begin : g_dec
         assign en_o[c] = (sel_i == SEL_W'(c));
      end
   endgenerate

   always_comb begin
      sdo_o = 1'b0;
      for (int c = 0; c < COLS; c++) begin
         if (sel_i == SEL_W'(c)) sdo_o = tail_i[c];
      end
   end

endmodule

// File: rtl/pixcfg_chain.sv
module pixcfg_chain
   import pixcfg_pkg::*;
#(
   parameter int ROWS     = 32,
   parameter int COLS     = 16,
   parameter int PIX_BITS = 8,
   localparam int CHAIN   = ROWS * PIX_BITS,
   localparam int SEL_W   = $clog2(COLS),
   localparam int IDX_W   = $clog2(CHAIN),
   localparam int TOTAL   = COLS * CHAIN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  col_sel,
   input  logic              sdi,
   input  logic              load,
   input  logic              readback,
   output logic              sdo,
   input  logic              strike_en,
   input  logic [SEL_W-1:0]  strike_col,
   input  logic [1:0]        strike_copy,
   input  logic [IDX_W-1:0]  strike_idx,
   output logic [TOTAL-1:0]  cfg_bits
);

   generate
      if (ROWS < 1 || PIX_BITS < 1 || CHAIN < 2) begin : g_bad_geom
         $error("pixcfg_chain: chain must hold at least two bits");
      end
      if (COLS < 2) begin : g_bad_cols
         $error("pixcfg_chain: at least two columns are needed");
      end
   endgenerate

   logic [COLS-1:0] col_en;
   logic [COLS-1:0] tail;
   logic [CHAIN-1:0] one_hot_idx;

   assign one_hot_idx = {{(CHAIN-1){1'b0}}, 1'b1} << strike_idx;

   pixcfg_colmux #(.COLS(COLS), .SEL_W(SEL_W)) u_mux (
      .sel_i  (col_sel),
      .tail_i (tail),
      .en_o   (col_en),
      .sdo_o  (sdo)
   );

   generate
      for (genvar c = 0; c < COLS; c++) begin : g_col
         chain_op_t         op;
         logic [CHAIN-1:0]  sr_q;
         logic [CHAIN-1:0]  voted;
         logic [2:0][CHAIN-1:0] flip;

         assign op = pick_op(col_en[c], load, readback);

         for (genvar k = 0; k < 3; k++) begin : g_flip
            assign flip[k] = (strike_en && strike_col == SEL_W'(c) && strike_copy == 2'(k))
                             ? one_hot_idx : '0;
         end

         pixcfg_shreg #(.W(CHAIN)) u_sr (
            .clk   (clk),
            .rst_n (rst_n),
            .op_i  (op),
            .sdi_i (sdi),
            .par_i (voted),
            .q_o   (sr_q)
         );

         pixcfg_tmr_store #(.W(CHAIN)) u_store (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (op == OP_LOAD),
            .data_i (sr_q),
            .flip_i (flip),
            .vote_o (voted)
         );

         assign tail[c] = sr_q[CHAIN-1];
         assign cfg_bits[c*CHAIN +: CHAIN] = voted;
      end
   endgenerate

   p_rb_priority_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (load && readback) |=> $stable(cfg_bits))
      else $error("configuration changed on a load-plus-readback edge");

   p_strike_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (strike_en && !load) |=> $stable(cfg_bits))
      else $error("a single-copy strike reached the configuration");

endmodule

// File: tb/pixcfg_chain_bench.sv
`timescale 1ns/1ps
module pixcfg_chain_bench;

   localparam int ROWS = 32, COLS = 16, PIX_BITS = 8;
   localparam int CHAIN = ROWS * PIX_BITS;
   localparam int SEL_W = 4, IDX_W = 8;

   logic clk = 1'b0;
   logic rst_n;
   logic [SEL_W-1:0] col_sel;
   logic sdi, load, readback, sdo;
   logic strike_en;
   logic [SEL_W-1:0] strike_col;
   logic [1:0] strike_copy;
   logic [IDX_W-1:0] strike_idx;
   logic [COLS*CHAIN-1:0] cfg_bits;

   always #2.5 clk = ~clk;

   pixcfg_chain #(.ROWS(ROWS), .COLS(COLS), .PIX_BITS(PIX_BITS)) u_pixcfg_chain (
      .clk(clk), .rst_n(rst_n), .col_sel(col_sel), .sdi(sdi), .load(load),
      .readback(readback), .sdo(sdo), .strike_en(strike_en), .strike_col(strike_col),
      .strike_copy(strike_copy), .strike_idx(strike_idx), .cfg_bits(cfg_bits)
   );

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;
   logic [CHAIN-1:0] m_sr [COLS];
   logic [CHAIN-1:0] m_cfg [COLS];

   function automatic logic [CHAIN-1:0] rand_vec();
      logic [CHAIN-1:0] v;
      for (int k = 0; k < CHAIN; k++) v[k] = 1'($urandom % 2);
      return v;
   endfunction

   task automatic chk_col(input int c, input string req);
      n_chk++;
      if (cfg_bits[c*CHAIN +: CHAIN] !== m_cfg[c]) begin
         n_err++;
         $display("FAIL %s col %0d: actual %h expected %h", req, c,
                  cfg_bits[c*CHAIN +: CHAIN], m_cfg[c]);
      end
   endtask

   task automatic chk_all(input string req);
      for (int c = 0; c < COLS; c++) chk_col(c, req);
   endtask

   task automatic chk_sdo(input logic exp, input string req);
      n_chk++;
      if (sdo !== exp) begin
         n_err++;
         $display("FAIL %s col %0d: sdo actual %b expected %b", req, col_sel, sdo, exp);
      end
   endtask

   // One rising edge, with the reference model updated from the requirements
   task automatic step();
      int c = int'(col_sel);
      if (readback)  m_sr[c] = m_cfg[c];
      else if (load) m_cfg[c] = m_sr[c];
      else           m_sr[c] = {m_sr[c][CHAIN-2:0], sdi};
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic shift_in(input int c, input logic [CHAIN-1:0] d);
      col_sel = SEL_W'(c); load = 0; readback = 0;
      for (int i = 0; i < CHAIN; i++) begin
         sdi = d[CHAIN-1-i];
         step();
      end
   endtask

   task automatic write_col(input int c, input logic [CHAIN-1:0] d);
      shift_in(c, d);
      load = 1; step(); load = 0;
      chk_col(c, "R3");
      chk_col((c + 1) % COLS, "R3");
   endtask

   task automatic shift_out(input int c, input logic [CHAIN-1:0] exp);
      col_sel = SEL_W'(c); load = 0; readback = 0;
      for (int i = 0; i < CHAIN; i++) begin
         chk_sdo(exp[CHAIN-1-i], "R4/R8");
         sdi = 1'($urandom % 2);
         step();
      end
   endtask

   task automatic read_col(input int c);
      logic [CHAIN-1:0] e = m_cfg[c];
      col_sel = SEL_W'(c); readback = 1; step(); readback = 0;
      shift_out(c, e);
   endtask

   task automatic strike(input int c, input int cp, input int idx);
      strike_en = 1; strike_col = SEL_W'(c); strike_copy = 2'(cp); strike_idx = IDX_W'(idx);
      step();
      strike_en = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired before all requirements were covered");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0c0f));
      rst_n = 0; col_sel = 0; sdi = 0; load = 0; readback = 0;
      strike_en = 0; strike_col = 0; strike_copy = 0; strike_idx = 0;
      for (int c = 0; c < COLS; c++) begin m_sr[c] = '0; m_cfg[c] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      chk_all("R1");
      chk_sdo(1'b0, "R1");

      // Alternating all-ones / all-zeros, then swapped
      for (int pass = 0; pass < 2; pass++) begin
         for (int c = 0; c < COLS; c++)
            write_col(c, ((c + pass) % 2 == 0) ? '1 : '0);
         chk_all("R9");
         for (int c = 0; c < COLS; c++) read_col(c);
         chk_all("R9");
      end

      // Random patterns on a few columns
      for (int j = 0; j < 4; j++) begin
         int c = int'($urandom % COLS);
         write_col(c, rand_vec());
         read_col(c);
      end

      // R2: an unselected chain keeps a half-finished pattern
      begin
         logic [CHAIN-1:0] a = rand_vec();
         shift_in(6, a);
         shift_in(7, rand_vec());
         col_sel = 6; load = 1; step(); load = 0;
         n_chk++;
         if (cfg_bits[6*CHAIN +: CHAIN] !== a) begin
            n_err++;
            $display("FAIL R2 col 6: actual %h expected %h", cfg_bits[6*CHAIN +: CHAIN], a);
         end
         chk_col(7, "R2");
      end

      // R5: load and readback together
      begin
         logic [CHAIN-1:0] keep;
         shift_in(3, rand_vec());
         keep = m_cfg[3];
         load = 1; readback = 1; step(); load = 0; readback = 0;
         chk_col(3, "R5");
         shift_out(3, keep);
      end

      // R6 / R7: strikes on each copy of the same bit, with repair edges between
      for (int j = 0; j < 12; j++) begin
         int c   = int'($urandom % COLS);
         int idx = int'($urandom % CHAIN);
         col_sel = SEL_W'((c + 1) % COLS);
         strike(c, 0, idx); chk_col(c, "R6");
         step();
         strike(c, 1, idx); chk_col(c, "R7");
         step();
         strike(c, 2, idx); chk_col(c, "R7");
         step();
         strike(c, 0, idx); chk_col(c, "R7");
         strike(c, 3, idx); chk_col(c, "R6");
      end
      for (int c = 0; c < COLS; c++) read_col(c);

      // R9: idle traffic with changing select
      for (int i = 0; i < 64; i++) begin
         col_sel = SEL_W'($urandom % COLS); sdi = 1'($urandom % 2);
         step();
      end
      chk_all("R9");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule